// File: doc/BRIEF.md
# Pin Edge Interrupt Detector

This block watches eight asynchronous pin inputs and turns their transitions into interrupt requests. Each input passes through a two-stage synchronizer. The block then compares the synchronized level with its value one cycle earlier. A low-to-high change sets a sticky bit in the rise status word, and a high-to-low change sets a sticky bit in the fall status word. Edges are captured whether or not the channel's interrupt is enabled. Software can therefore poll the status words and use the interrupt lines, or it can leave the interrupts off.

Each status word clears bit by bit when software writes ones to it. Two enable masks, one for rising edges and one for falling edges, decide which status bits reach the interrupt lines. Each mask has its own set address and its own clear address. Software can change single bits without a read-modify-write, and it can read each mask back at a separate address. Channel n raises `irq[n]` while its rise status bit is set and enabled, or while its fall status bit is set and enabled.

Access is through a plain register port: a byte address, 32-bit write data, a write strobe and a combinational read-data output. Word offsets, using `addr[5:2]` with `addr[1:0]` equal to 0: 0 rise-enable readback, 1 rise-enable set, 2 rise-enable clear, 3 fall-enable readback, 4 fall-enable set, 5 fall-enable clear, 6 rise status, 7 fall status, 8 pending interrupts (read-only).

Top module: `pin_edge_irq`

## Requirements
- R1: Bits 31:8 of every read are 0. Reads of the set/clear addresses (byte 0x04, 0x08, 0x10, 0x14), of unmapped offsets (0x24 and up) and of any address with `addr[1:0]` not 0 return 0. Writes to unmapped or misaligned addresses change nothing.
- R2: A low-to-high change on `pin_in[n]` sets bit n of the rise status word (byte 0x18). The change is applied between clock edges. The bit becomes visible after the third rising clock edge that follows the change, and not after the second.
- R3: A high-to-low change on `pin_in[n]` sets bit n of the fall status word (byte 0x1C), with the same three-edge latency.
- R4: Writing a 1 to bit n of byte 0x18 or 0x1C clears that status bit at the next clock edge. A 0 bit in the write data leaves the status bit unchanged.
- R5: While `rst` is high at a clock edge, the block clears both status words, both enable masks, the synchronizer state and `irq`.
- R6: Edges are recorded in the status words when the matching enable bit is 0.
- R7: `irq[n]` equals (rise status[n] AND rise enable[n]) OR (fall status[n] AND fall enable[n]).
- R8: Writing ones to byte 0x04 (rise) or 0x10 (fall) sets the matching enable bits, and zero bits leave them unchanged. The masks read back at byte 0x00 (rise) and 0x0C (fall).
- R9: Writing ones to byte 0x08 (rise) or 0x14 (fall) clears the matching enable bits, and zero bits leave them unchanged.
- R10: If an edge is detected on a channel in the same cycle as a write-one clear of that channel's status bit, the bit stays set.
- R11: A read of byte 0x20 returns the current `irq` vector in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Asynchronous pin levels, one per channel |
| addr | input | 6 | Byte address of the register access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per high cycle |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 8 | Interrupt request per channel |

## Verification
The bench checks the exact detection latency. A design with one synchronizer stage too few would set the status bit one edge early, and a design with one stage too many would set it one edge late. It checks that an edge landing in the same cycle as its own clear survives. A design that gives the clear priority would lose that interrupt without any trace. It checks that zero bits in set and clear writes leave the enables alone, and that reserved, write-only and misaligned addresses read as zero. A decode that ignores the low address bits or echoes write-only registers would show up in these reads. Finally, a long stretch of pseudo-random pin toggling mixed with random writes is compared every cycle against a behavioural model. This catches swapped rise and fall paths and enables that are gated onto the wrong status word.

// File: rtl/pin_edge_irq_pkg.sv
package pin_edge_irq_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic [3:0] {
        SEL_RISE_EN      = 4'd0,
        SEL_RISE_EN_SET  = 4'd1,
        SEL_RISE_EN_CLR  = 4'd2,
        SEL_FALL_EN      = 4'd3,
        SEL_FALL_EN_SET  = 4'd4,
        SEL_FALL_EN_CLR  = 4'd5,
        SEL_RISE_STAT    = 4'd6,
        SEL_FALL_STAT    = 4'd7,
        SEL_PENDING      = 4'd8,
        SEL_NONE         = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic rise_en_set;
        logic rise_en_clr;
        logic fall_en_set;
        logic fall_en_clr;
        logic rise_stat_clr;
        logic fall_stat_clr;
    } wr_strobe_t;

    // Word index plus alignment flag to register selector.
    function automatic reg_sel_e decode_word(input logic [7:0] idx, input logic aligned);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (aligned) begin
            case (idx)
                8'd0: sel = SEL_RISE_EN;
                8'd1: sel = SEL_RISE_EN_SET;
                8'd2: sel = SEL_RISE_EN_CLR;
                8'd3: sel = SEL_FALL_EN;
                8'd4: sel = SEL_FALL_EN_SET;
                8'd5: sel = SEL_FALL_EN_CLR;
                8'd6: sel = SEL_RISE_STAT;
                8'd7: sel = SEL_FALL_STAT;
                8'd8: sel = SEL_PENDING;
                default: sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

    function automatic wr_strobe_t write_strobes(input reg_sel_e sel, input logic wr);
        wr_strobe_t s;
        s = '0;
        if (wr) begin
            s.rise_en_set   = (sel == SEL_RISE_EN_SET);
            s.rise_en_clr   = (sel == SEL_RISE_EN_CLR);
            s.fall_en_set   = (sel == SEL_FALL_EN_SET);
            s.fall_en_clr   = (sel == SEL_FALL_EN_CLR);
            s.rise_stat_clr = (sel == SEL_RISE_STAT);
            s.fall_stat_clr = (sel == SEL_FALL_STAT);
        end
        return s;
    endfunction

endpackage

// File: rtl/pei_edge_detect.sv
module pei_edge_detect
    import pin_edge_irq_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] pin_i,
    output logic [N_CH-1:0] rise_o,
    output logic [N_CH-1:0] fall_o
);

    localparam int MSB = STAGES - 1;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], pin_i[ch]};
                prev  <= chain[MSB];
            end
        end

        assign rise_o[ch] =  chain[MSB] & ~prev;
        assign fall_o[ch] = ~chain[MSB] &  prev;
    end

    // R2: a detected edge is a single-cycle pulse
    a_r2_rise_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
    // R3: same for falling edges
    a_r3_fall_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (|fall_o) |=> ((fall_o & $past(fall_o)) == '0));

endmodule

// File: rtl/pei_sticky.sv
module pei_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q;

    // Set has priority over clear (R10).
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_i) | set_i;
    end

    assign q_o = q;

    // R4 / R9: a clear without a coincident set empties the bit
    a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (|(clr_i & ~set_i)) |=> ((q & $past(clr_i & ~set_i)) == '0));
    // R10: a set always lands, even alongside a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q & $past(set_i)) == $past(set_i)));
    // R6 / R8: bits rise only when set
    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & ~$past(q) & ~$past(set_i)) == '0));

endmodule

// File: rtl/pei_regfile.sv
module pei_regfile
    import pin_edge_irq_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic [N_CH-1:0]   rise_stat,
    input  logic [N_CH-1:0]   fall_stat,
    input  logic [N_CH-1:0]   pending,
    output logic [N_CH-1:0]   rise_en,
    output logic [N_CH-1:0]   fall_en,
    output logic [N_CH-1:0]   rise_clr,
    output logic [N_CH-1:0]   fall_clr,
    output logic [DATA_W-1:0] rdata
);

    reg_sel_e     sel;
    wr_strobe_t   stb;
    logic [N_CH-1:0] wmask;
    logic         unused_wdata_hi;

    assign sel   = decode_word(8'(addr[ADDR_W-1:2]), addr[1:0] == 2'b00);
    assign stb   = write_strobes(sel, wr_en);
    assign wmask = wdata[N_CH-1:0];
    assign unused_wdata_hi = ^wdata[DATA_W-1:N_CH];

    assign rise_clr = stb.rise_stat_clr ? wmask : '0;
    assign fall_clr = stb.fall_stat_clr ? wmask : '0;

    pei_sticky #(.W(N_CH)) u_rise_en (
        .clk  (clk),
        .rst  (rst),
        .set_i(stb.rise_en_set ? wmask : '0),
        .clr_i(stb.rise_en_clr ? wmask : '0),
        .q_o  (rise_en)
    );

    pei_sticky #(.W(N_CH)) u_fall_en (
        .clk  (clk),
        .rst  (rst),
        .set_i(stb.fall_en_set ? wmask : '0),
        .clr_i(stb.fall_en_clr ? wmask : '0),
        .q_o  (fall_en)
    );

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_RISE_EN:   rdata[N_CH-1:0] = rise_en;
            SEL_FALL_EN:   rdata[N_CH-1:0] = fall_en;
            SEL_RISE_STAT: rdata[N_CH-1:0] = rise_stat;
            SEL_FALL_STAT: rdata[N_CH-1:0] = fall_stat;
            SEL_PENDING:   rdata[N_CH-1:0] = pending;
            default:       rdata = '0;
        endcase
    end

    // R1: reserved read bits stay zero
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-1:N_CH] == '0);
    // R8: set write leaves the written ones present in the mask
    a_r8_rise_set: assert property (@(posedge clk) disable iff (rst)
        stb.rise_en_set |=> ((rise_en & $past(wmask)) == $past(wmask)));
    // R9: clear write removes the written ones from the mask
    a_r9_fall_clr: assert property (@(posedge clk) disable iff (rst)
        stb.fall_en_clr |=> ((fall_en & $past(wmask)) == '0));
    // R8 / R9: enables hold when no enable write occurs
    a_r8_en_hold: assert property (@(posedge clk) disable iff (rst)
        !(stb.rise_en_set || stb.rise_en_clr) |=> $stable(rise_en));

endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq
    import pin_edge_irq_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   pin_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rdata,
    output logic [N_CH-1:0]   irq
);

    logic [N_CH-1:0] rise_edge, fall_edge;
    logic [N_CH-1:0] rise_stat, fall_stat;
    logic [N_CH-1:0] rise_en, fall_en;
    logic [N_CH-1:0] rise_clr, fall_clr;

    pei_edge_detect #(.N_CH(N_CH)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_in),
        .rise_o(rise_edge),
        .fall_o(fall_edge)
    );

    pei_sticky #(.W(N_CH)) u_rise_stat (
        .clk  (clk),
        .rst  (rst),
        .set_i(rise_edge),
        .clr_i(rise_clr),
        .q_o  (rise_stat)
    );

    pei_sticky #(.W(N_CH)) u_fall_stat (
        .clk  (clk),
        .rst  (rst),
        .set_i(fall_edge),
        .clr_i(fall_clr),
        .q_o  (fall_stat)
    );

    pei_regfile #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rise_stat(rise_stat),
        .fall_stat(fall_stat),
        .pending  (irq),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .rise_clr (rise_clr),
        .fall_clr (fall_clr),
        .rdata    (rdata)
    );

    assign irq = (rise_stat & rise_en) | (fall_stat & fall_en);

    // R7: a request is always backed by a recorded edge
    a_r7_irq_backed: assert property (@(posedge clk) disable iff (rst)
        (irq & ~(rise_stat | fall_stat)) == '0);
    // R5: reset leaves no request pending
    a_r5_reset_quiet: assert property (@(posedge clk)
        rst |=> (irq == '0));

endmodule

// File: tb/pin_edge_irq_test.sv
`timescale 1ns/1ps
module pin_edge_irq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin_in = '0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rdata;
    logic [7:0]  irq;

    int nchecks = 0;
    int nerrors = 0;

    always #2.5 clk = ~clk;

    pin_edge_irq uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .addr(addr),
        .wdata(wdata), .wr_en(wr_en), .rdata(rdata), .irq(irq)
    );

    // Behavioural model
    logic [7:0] m_rs = '0, m_fs = '0, m_re = '0, m_fe = '0;
    logic [7:0] hist[$];

    function automatic logic [7:0] exp_irq();
        return (m_rs & m_re) | (m_fs & m_fe);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [5:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[5:2])
            4'd0: return {24'h0, m_re};
            4'd3: return {24'h0, m_fe};
            4'd6: return {24'h0, m_rs};
            4'd7: return {24'h0, m_fs};
            4'd8: return {24'h0, exp_irq()};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [5:0] a);
        if (a[1:0] != 2'b00) return "R1";
        case (a[5:2])
            4'd0, 4'd3: return "R8";
            4'd6: return "R2";
            4'd7: return "R3";
            4'd8: return "R11";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        logic [7:0] r_e, f_e, wm;
        logic [7:0] n_rs, n_fs, n_re, n_fe;
        logic       al;
        r_e = hist[1] & ~hist[2];
        f_e = ~hist[1] & hist[2];
        wm  = wr_en ? wdata[7:0] : 8'h0;
        al  = (addr[1:0] == 2'b00);
        n_re = m_re; n_fe = m_fe;
        n_rs = m_rs | r_e; n_fs = m_fs | f_e;
        if (al) begin
            case (addr[5:2])
                4'd1: n_re = m_re | wm;
                4'd2: n_re = m_re & ~wm;
                4'd4: n_fe = m_fe | wm;
                4'd5: n_fe = m_fe & ~wm;
                4'd6: n_rs = (m_rs & ~wm) | r_e;
                4'd7: n_fs = (m_fs & ~wm) | f_e;
                default: ;
            endcase
        end
        @(posedge clk);
        if (rst) begin
            m_rs = '0; m_fs = '0; m_re = '0; m_fe = '0;
            hist = '{8'h0, 8'h0, 8'h0};
        end else begin
            m_rs = n_rs; m_fs = n_fs; m_re = n_re; m_fe = n_fe;
            hist.push_front(pin_in);
            void'(hist.pop_back());
        end
        @(negedge clk);
        chk("R7", {24'h0, irq}, {24'h0, exp_irq()});
        chk(tag_for(addr), rdata, exp_rd(addr));
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        addr = a;
        #0.5;
        chk(req, rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        nerrors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

    initial begin : stim
        logic [15:0] lfsr;
        hist = '{8'h0, 8'h0, 8'h0};
        @(negedge clk);
        ticks(3);
        rst = 1'b0;
        // R5: reset state
        for (int a = 0; a < 64; a += 4) rd_chk("R5", 6'(a), 32'h0);
        chk("R5", {24'h0, irq}, 32'h0);

        // R2 latency and R6 (enable off)
        pin_in[1] = 1'b1;
        ticks(2);
        rd_chk("R2", 6'h18, 32'h0);
        tick();
        rd_chk("R2", 6'h18, 32'h02);
        chk("R6", {24'h0, irq}, 32'h0);

        // R3: falling edge
        pin_in[1] = 1'b0;
        ticks(3);
        rd_chk("R3", 6'h1C, 32'h02);

        // R8: set rise enables, zero bits inert, readback
        wr(6'h04, 32'h0000_000F);
        rd_chk("R8", 6'h00, 32'h0F);
        wr(6'h04, 32'h0000_0000);
        rd_chk("R8", 6'h00, 32'h0F);
        chk("R7", {24'h0, irq}, 32'h02);
        rd_chk("R11", 6'h20, 32'h02);

        // R4: write-one-to-clear, zero write inert
        wr(6'h1C, 32'h0);
        rd_chk("R4", 6'h1C, 32'h02);
        wr(6'h18, 32'h02);
        rd_chk("R4", 6'h18, 32'h0);
        chk("R4", {24'h0, irq}, 32'h0);

        // R7 via fall enable; R9 clear
        wr(6'h10, 32'h02);
        chk("R7", {24'h0, irq}, 32'h02);
        wr(6'h14, 32'h02);
        rd_chk("R9", 6'h0C, 32'h0);
        chk("R9", {24'h0, irq}, 32'h0);
        wr(6'h08, 32'h05);
        rd_chk("R9", 6'h00, 32'h0A);

        // R10: edge coincident with clear
        pin_in[2] = 1'b1;
        ticks(2);
        wr(6'h18, 32'h04);
        rd_chk("R10", 6'h18, 32'h04);
        wr(6'h18, 32'h04);
        rd_chk("R4", 6'h18, 32'h0);

        // R1: reserved bits, write-only and misaligned addresses
        wr(6'h04, 32'hFFFF_FF00);
        rd_chk("R1", 6'h00, 32'h0A);
        rd_chk("R1", 6'h04, 32'h0);
        rd_chk("R1", 6'h14, 32'h0);
        wr(6'h05, 32'h0000_00FF);
        rd_chk("R1", 6'h00, 32'h0A);
        rd_chk("R1", 6'h01, 32'h0);
        rd_chk("R1", 6'h30, 32'h0);

        // Mixed pseudo-random traffic, compared every cycle
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) pin_in = lfsr[15:8];
            if (lfsr[6:4] == 3'd1) wr(6'(lfsr[11:8] * 4), {24'h0, lfsr[7:0]});
            else if (lfsr[6:4] == 3'd2) wr(6'(lfsr[13:8]), {24'h0, lfsr[15:8]});
            else begin
                addr = 6'(lfsr[12:9] * 4);
                tick();
            end
        end

        // R5: reset mid-run clears everything
        rst = 1'b1;
        tick();
        rst = 1'b0;
        pin_in = '0;
        rd_chk("R5", 6'h20, 32'h0);
        rd_chk("R5", 6'h00, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
        $finish;
    end

endmodule